// File: doc/BRIEF.md
# Field-Configurable Sum-of-Products Logic Array

This block is a small configurable logic array. Four logic inputs, each offered in true and inverted form, feed sixteen product terms through a fully programmable AND plane. Each of the four outputs then sums any chosen subset of those sixteen terms through a programmable OR plane. Because the OR plane is programmable too, one product term can feed several outputs at the same time. Any two-level function of the four inputs that needs no more than sixteen distinct products can be built.

The connection bits live in a serial configuration chain of 192 bits. A loader raises the enable, shifts one bit per clock and then lowers the enable. A done flag shows that the last session shifted a complete image. The bit that falls off the far end of the chain is presented on a readback pin, so the loader can verify the previous image while it shifts in the next one. Outside configuration the path from the inputs to the outputs is purely combinational. During configuration the outputs are held low.

Top module: `pla_core`

## Requirements
- R1: After reset every connection bit is intact (1), so every product term evaluates to 0 and every output is 0 for all inputs. `cfg_dout` reads 1 and `cfg_done` reads 0.
- R2: Each input i gives two literals to every product term. Literal slot 2*i carries the input itself and slot 2*i+1 carries its complement.
- R3: A product term is the AND of the literals whose bits are 1. A term with no literal connected evaluates to 1, and a term that holds both a literal and its complement evaluates to 0.
- R4: Output o is the OR of the product terms whose OR-plane bit is 1. An output with no terms selected is 0.
- R5: A single product term that is selected by several outputs drives all of them at once.
- R6: The k-th bit shifted in (k counted from 0) sets one connection, as follows. For k < 128 it is AND bit k = 8*t + slot, for term t. For 128 <= k < 192 it is the OR bit of output o = (k-128)/16 and term t = (k-128)%16. Extra shifts push older bits further along, so after n more shifts bit k holds the earlier bit k+n.
- R7: While `cfg_en` is high, `cfg_dout` shows the oldest bit before each shift. Shifting a new 192-bit image therefore returns the previous image in the order it was loaded.
- R8: While `cfg_en` is high, every output is 0 whatever the inputs and the partial image are.
- R9: When `cfg_en` is low the chain holds its contents and `cfg_din` and the clock have no effect. After a session of at least 192 shifts, `cfg_done` is high once `cfg_en` goes low.
- R10: `cfg_done` is low during a session and after a session of fewer than 192 shifts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration shift clock |
| rst_n | input | 1 | Asynchronous active-low reset, restores the erased image |
| cfg_en | input | 1 | Shift enable, one chain step per clock while high |
| cfg_din | input | 1 | Serial configuration data in |
| cfg_dout | output | 1 | Serial readback, oldest bit in the chain |
| cfg_done | output | 1 | A complete image has been loaded |
| in_i | input | 4 | Logic inputs |
| q_o | output | 4 | Sum-of-products outputs |

## Verification
The evaluation path and the configuration path can be active in the same cycle. This happens when the inputs change while a new image is being shifted and the chain holds a half-written mix of old and new bits. The bench provokes this by changing the inputs halfway through a load and judges it by requiring all-zero outputs. It also requires that readback of the old image runs unaffected in that same session. A second overlap happens when a session ends early. The bench computes the shifted-mix image on its own and checks every input combination against the model evaluated on that image. It also checks that the done flag stays low.

// File: rtl/pla_pkg.sv
package pla_pkg;
   // literal slot of input i, inverted form when comp is set
   function automatic int lit_slot(input int i, input bit comp);
      return 2 * i + (comp ? 1 : 0);
   endfunction

   // total chain length for a given geometry
   function automatic int chain_bits(input int n_in, input int n_term, input int n_out);
      return n_term * 2 * n_in + n_term * n_out;
   endfunction
endpackage

// File: rtl/pla_fuse_chain.sv
module pla_fuse_chain #(
   parameter int N_IN   = 4,
   parameter int N_TERM = 16,
   parameter int N_OUT  = 4
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        cfg_en,
   input  logic                        cfg_din,
   output logic                        cfg_dout,
   output logic                        cfg_done,
   output logic [N_TERM*2*N_IN-1:0]    and_fuse,
   output logic [N_OUT*N_TERM-1:0]     or_fuse
);
   localparam int N_LIT    = 2 * N_IN;
   localparam int AND_BITS = N_TERM * N_LIT;
   localparam int OR_BITS  = N_OUT * N_TERM;
   localparam int LEN      = pla_pkg::chain_bits(N_IN, N_TERM, N_OUT);
   localparam int CW       = $clog2(LEN + 1);
   localparam logic [CW-1:0] FULL = CW'(LEN);

   logic [LEN-1:0] chain_q;
   logic [CW-1:0]  cnt_q;
   logic           en_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '1;
         cnt_q   <= '0;
         en_q    <= 1'b0;
      end else begin
         en_q <= cfg_en;
         if (cfg_en) begin
            chain_q <= {chain_q[LEN-2:0], cfg_din};
            if (!en_q)
               cnt_q <= CW'(1);
            else if (cnt_q != FULL)
               cnt_q <= cnt_q + CW'(1);
         end
      end
   end

   assign cfg_dout = chain_q[LEN-1];
   assign cfg_done = !cfg_en && (cnt_q == FULL);

   // bit shifted in k-th sits at chain position LEN-1-k
   for (genvar k = 0; k < AND_BITS; k++) begin : g_and_map
      assign and_fuse[k] = chain_q[LEN-1-k];
   end
   for (genvar k = 0; k < OR_BITS; k++) begin : g_or_map
      assign or_fuse[k] = chain_q[LEN-1-AND_BITS-k];
   end

   // R9: chain is frozen whenever shifting is disabled
   p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_en |=> $stable(chain_q));
   // R10: shift counter saturates at the image length
   p_count_cap_r10: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= FULL);
endmodule

// File: rtl/pla_and_plane.sv
module pla_and_plane #(
   parameter int N_IN   = 4,
   parameter int N_TERM = 16
) (
   input  logic [N_IN-1:0]             in_i,
   input  logic [N_TERM*2*N_IN-1:0]    and_fuse,
   output logic [N_TERM-1:0]           term_o
);
   localparam int N_LIT = 2 * N_IN;

   logic [N_LIT-1:0] lit;

   for (genvar i = 0; i < N_IN; i++) begin : g_lit
      assign lit[pla_pkg::lit_slot(i, 1'b0)] = in_i[i];
      assign lit[pla_pkg::lit_slot(i, 1'b1)] = ~in_i[i];
   end

   // a blown crosspoint contributes a constant 1 to the product
   for (genvar t = 0; t < N_TERM; t++) begin : g_term
      assign term_o[t] = &(~and_fuse[t*N_LIT +: N_LIT] | lit);
   end
endmodule

// File: rtl/pla_or_plane.sv
module pla_or_plane #(
   parameter int N_TERM = 16,
   parameter int N_OUT  = 4
) (
   input  logic [N_TERM-1:0]           term_i,
   input  logic [N_OUT*N_TERM-1:0]     or_fuse,
   output logic [N_OUT-1:0]            sum_o
);
   for (genvar o = 0; o < N_OUT; o++) begin : g_sum
      assign sum_o[o] = |(or_fuse[o*N_TERM +: N_TERM] & term_i);
   end
endmodule

// File: rtl/pla_core.sv
module pla_core #(
   parameter int N_IN   = 4,
   parameter int N_TERM = 16,
   parameter int N_OUT  = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_en,
   input  logic             cfg_din,
   output logic             cfg_dout,
   output logic             cfg_done,
   input  logic [N_IN-1:0]  in_i,
   output logic [N_OUT-1:0] q_o
);
   localparam int N_LIT    = 2 * N_IN;
   localparam int AND_BITS = N_TERM * N_LIT;
   localparam int OR_BITS  = N_OUT * N_TERM;

   if (N_IN < 1 || N_TERM < 2 || N_OUT < 1) begin : g_bad_geom
      $error("pla_core: geometry parameters out of range");
   end

   logic [AND_BITS-1:0] and_fuse;
   logic [OR_BITS-1:0]  or_fuse;
   logic [N_TERM-1:0]   term;
   logic [N_OUT-1:0]    sum;

   pla_fuse_chain #(.N_IN(N_IN), .N_TERM(N_TERM), .N_OUT(N_OUT)) u_chain (
      .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_din(cfg_din),
      .cfg_dout(cfg_dout), .cfg_done(cfg_done),
      .and_fuse(and_fuse), .or_fuse(or_fuse));

   pla_and_plane #(.N_IN(N_IN), .N_TERM(N_TERM)) u_and (
      .in_i(in_i), .and_fuse(and_fuse), .term_o(term));

   pla_or_plane #(.N_TERM(N_TERM), .N_OUT(N_OUT)) u_or (
      .term_i(term), .or_fuse(or_fuse), .sum_o(sum));

   assign q_o = cfg_en ? '0 : sum;

   // R3: a product with every crosspoint blown is always true
   for (genvar t = 0; t < N_TERM; t++) begin : g_chk_term
      p_blank_term_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (and_fuse[t*N_LIT +: N_LIT] == '0) |-> term[t]);
   end

   // R4: an output that selects no term stays low
   for (genvar o = 0; o < N_OUT; o++) begin : g_chk_out
      p_empty_out_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (or_fuse[o*N_TERM +: N_TERM] == '0) |-> !q_o[o]);
   end

   // R8: no output activity while an image is being shifted
   p_cfg_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_en |-> (q_o == '0));
endmodule

// File: tb/sim_pla_core.sv
module sim_pla_core;
   localparam int LEN = 192;
   localparam int AB  = 128;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_en = 1'b0;
   logic cfg_din = 1'b0;
   logic [3:0] in_i = '0;
   logic cfg_dout, cfg_done;
   logic [3:0] q_o;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   logic [LEN-1:0] cur;   // image in chain, bit k = k-th shifted

   always #10 clk = ~clk;

   pla_core u0 (.clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_din(cfg_din),
                .cfg_dout(cfg_dout), .cfg_done(cfg_done), .in_i(in_i), .q_o(q_o));

   task automatic chk(input bit ok, input string req,
                      input logic [LEN-1:0] act, input logic [LEN-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [3:0] model_q(input logic [LEN-1:0] p, input logic [3:0] x);
      logic [3:0] r = '0;
      for (int o = 0; o < 4; o++) begin
         for (int t = 0; t < 16; t++) begin
            if (p[AB + o*16 + t]) begin
               logic prod = 1'b1;
               for (int l = 0; l < 8; l++)
                  if (p[t*8 + l]) prod &= l[0] ? ~x[l>>1] : x[l>>1];
               r[o] |= prod;
            end
         end
      end
      return r;
   endfunction

   task automatic check_all_inputs(input string req);
      for (int v = 0; v < 16; v++) begin
         @(negedge clk);
         in_i = v[3:0];
         #1;
         chk(q_o == model_q(cur, v[3:0]), req, LEN'(q_o), LEN'(model_q(cur, v[3:0])));
      end
   endtask

   // shift n bits of img (bit 0 first); returns readback; checks quiet outputs
   task automatic shift_in(input logic [LEN-1:0] img, input int n,
                           output logic [LEN-1:0] rb);
      rb = '0;
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         rb[k] = cfg_dout;
         cfg_din = img[k];
         cfg_en = 1'b1;
         if (k == n/2) begin
            in_i = 4'(k);
            #1;
            chk(q_o == 4'h0, "R8 quiet during shift", LEN'(q_o), '0);
            chk(cfg_done == 1'b0, "R10 done low in session", LEN'(cfg_done), '0);
         end
      end
      @(negedge clk);
      cfg_en = 1'b0;
      #1;
      cur = (n >= LEN) ? img : ((cur >> n) | (img << (LEN - n)));
   endtask

   function automatic logic [LEN-1:0] rand_img();
      logic [LEN-1:0] p;
      for (int k = 0; k < LEN; k++)
         p[k] = (k < AB) ? (($urandom % 4) == 0) : ($urandom % 2 == 1);
      // keep one term blank so it acts as constant true
      if ($urandom % 2 == 1) p[($urandom % 16)*8 +: 8] = '0;
      return p;
   endfunction

   initial begin
      #(20 * 150000);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [LEN-1:0] img, prev, rb;
      void'($urandom(32'h1A2B3C));
      cur = '1;
      #35 rst_n = 1'b1;

      // R1 reset state
      #1;
      chk(cfg_dout == 1'b1, "R1 dout after reset", LEN'(cfg_dout), 1);
      chk(cfg_done == 1'b0, "R1 done after reset", LEN'(cfg_done), 0);
      check_all_inputs("R1 erased image gives zero");

      // directed: XOR on Q0, shared term on Q1, blank term on Q3, nothing on Q2
      img = '0;
      img[0*8 + 0] = 1'b1; img[0*8 + 3] = 1'b1;   // R2 term0 = I0 & /I1
      img[1*8 + 1] = 1'b1; img[1*8 + 2] = 1'b1;   // term1 = /I0 & I1
      for (int t = 2; t < 15; t++) img[t*8 +: 8] = '1;  // R3 X and /X -> 0
      img[AB + 0*16 + 0] = 1'b1; img[AB + 0*16 + 1] = 1'b1;
      img[AB + 1*16 + 0] = 1'b1;                  // R5 term0 shared
      img[AB + 3*16 + 15] = 1'b1;                 // R3 blank term -> 1
      img[AB + 3*16 + 2] = 1'b1;                  // contradictory term
      shift_in(img, LEN, rb);
      chk(rb == '1, "R7 readback of erased image", rb, '1);
      chk(cfg_done == 1'b1, "R9 done after full image", LEN'(cfg_done), 1);
      for (int v = 0; v < 16; v++) begin
         logic [3:0] e;
         e[0] = v[0] ^ v[1];
         e[1] = v[0] & ~v[1];
         e[2] = 1'b0;
         e[3] = 1'b1;
         @(negedge clk);
         in_i = v[3:0];
         #1;
         chk(q_o == e, "R4 R5 directed sum of products", LEN'(q_o), LEN'(e));
      end
      prev = img;

      // R9 idle: toggle din with enable low, image must persist
      for (int k = 0; k < 8; k++) begin
         @(negedge clk);
         cfg_din = k[0];
      end
      check_all_inputs("R9 idle clocks ignored");
      chk(cfg_done == 1'b1, "R9 done holds while idle", LEN'(cfg_done), 1);

      // R6 R10 short session: 10 extra bits move older bits along
      img = rand_img();
      shift_in(img, 10, rb);
      chk(rb[9:0] == prev[9:0], "R7 partial readback", LEN'(rb[9:0]), LEN'(prev[9:0]));
      chk(cfg_done == 1'b0, "R10 done low after short session", LEN'(cfg_done), 0);
      check_all_inputs("R6 shifted mix image");
      prev = cur;

      // random images, readback of each previous one
      for (int n = 0; n < 12; n++) begin
         img = rand_img();
         shift_in(img, LEN, rb);
         chk(rb == prev, "R7 readback of previous image", rb, prev);
         chk(cfg_done == 1'b1, "R9 done after random image", LEN'(cfg_done), 1);
         check_all_inputs("R2 R3 R4 R6 random image");
         prev = img;
      end

      // reset restores erased image
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      cur = '1;
      chk(cfg_dout == 1'b1, "R1 dout after second reset", LEN'(cfg_dout), 1);
      @(negedge clk);
      rst_n = 1'b1;
      check_all_inputs("R1 erased after second reset");

      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule